// File: doc/BRIEF.md
# Memory-Mapped Semihosting Doorbell

This block is a 32-byte register window on a simple byte-wide slave bus. A guest processor uses it to ask a host for I/O services without any special instructions, using only loads and stores. The guest finds the device by reading an ASCII signature. It stores the address of a message buffer in a 16-byte pointer register. It then writes any value to a doorbell byte, which sends a one-cycle request pulse to the host side. The full pointer is presented in parallel with that pulse.

The host side parses the message and performs the I/O. Both of those tasks are outside this block. When the host is finished it returns a completion strobe, which may carry an error flag and an error code. The guest polls a status byte until the ready flag appears. Errors are reported in their own register, so the host never has to write into guest memory to report a failure.

Top module: `semi_doorbell`

## Requirements
- R1: Reads at offsets 0x00..0x07 return the bytes 0x53,0x45,0x4D,0x49,0x48,0x4F,0x53,0x54 ("SEMIHOST") in ascending offset order.
- R2: Offsets 0x08..0x17 form a read/write pointer register. The byte at offset 0x08+k reads back what was last written there, and it drives `host_ptr[8k+7:8k]`.
- R3: A write of any value to offset 0x18 while idle does three things. It makes `host_req` high for exactly the one cycle after the write. It sets the block busy. It clears status bits 1 and 2 and the error code at 0x1A.
- R4: A doorbell write while busy is ignored and produces no `host_req` pulse.
- R5: A `host_done` strobe while busy clears busy and sets status bit 1 (ready). A strobe while idle changes nothing.
- R6: A `host_done` strobe with `host_err` high while busy also sets status bit 2 (protocol error) and loads `host_err_code` into the register at 0x1A.
- R7: Status bit 0 (offset 0x19) follows the `host_timer` input.
- R8: Offsets 0x18 and 0x1B..0x1F read as zero. Writes to offsets 0x00..0x07, 0x19 and 0x1A have no effect.
- R9: Writes to the pointer register are ignored while busy.
- R10: After reset the pointer, the status flags, the error code and busy are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Byte offset in the window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| host_req | output | 1 | One-cycle request pulse to the host |
| host_ptr | output | 128 | Buffer pointer, byte 0 in the low bits |
| host_done | input | 1 | Host completion strobe |
| host_err | input | 1 | Completion carries a protocol error |
| host_err_code | input | 8 | Error code captured with an error completion |
| host_timer | input | 1 | Timer flag level shown in status bit 0 |

## Verification
The hardest state to reach is the busy window. While a request is outstanding, the guest may ring the doorbell again or overwrite the pointer, and neither action may reach the host. The bench reaches this state by ringing the doorbell and then holding back `host_done`. During that gap it issues a second doorbell and a pointer write, then checks that no extra pulse appears and that the pointer reads back unchanged. It repeats this over several doorbell data values and alternates clean and error completions, so that the next doorbell is shown to clear flags left over from both kinds of completion.

// File: rtl/semi_doorbell.sv
module semi_doorbell #(
  parameter int PTR_BYTES = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [4:0]             bus_addr,
  input  logic                   bus_wr,
  input  logic [7:0]             bus_wdata,
  output logic [7:0]             bus_rdata,
  output logic                   host_req,
  output logic [PTR_BYTES*8-1:0] host_ptr,
  input  logic                   host_done,
  input  logic                   host_err,
  input  logic [7:0]             host_err_code,
  input  logic                   host_timer
);
  localparam logic [4:0] PTR_LO  = 5'h08;
  localparam logic [4:0] BELL    = 5'h18;
  localparam logic [4:0] STAT    = 5'h19;
  localparam logic [4:0] ECODE   = 5'h1A;
  localparam logic [63:0] SIG    = 64'h54534F48494D4553;

  logic [PTR_BYTES*8-1:0] ptr_q;
  logic       busy_q, ready_q, perr_q, req_q;
  logic [7:0] err_q;
  logic [4:0] poff;
  logic       in_ptr, ring;

  assign poff   = bus_addr - PTR_LO;
  assign in_ptr = (bus_addr >= PTR_LO) && (bus_addr < PTR_LO + 5'(PTR_BYTES));
  assign ring   = bus_wr && (bus_addr == BELL) && !busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      busy_q  <= 1'b0;
      ready_q <= 1'b0;
      perr_q  <= 1'b0;
      err_q   <= '0;
      req_q   <= 1'b0;
    end else begin
      req_q <= ring;
      if (bus_wr && in_ptr && !busy_q)
        ptr_q[8*poff[3:0] +: 8] <= bus_wdata;
      if (ring) begin
        busy_q  <= 1'b1;
        ready_q <= 1'b0;
        perr_q  <= 1'b0;
        err_q   <= '0;
      end else if (busy_q && host_done) begin
        busy_q  <= 1'b0;
        ready_q <= 1'b1;
        if (host_err) begin
          perr_q <= 1'b1;
          err_q  <= host_err_code;
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr < PTR_LO)      bus_rdata = SIG[8*bus_addr[2:0] +: 8];
    else if (in_ptr)            bus_rdata = ptr_q[8*poff[3:0] +: 8];
    else if (bus_addr == STAT)  bus_rdata = {5'b0, perr_q, ready_q, host_timer};
    else if (bus_addr == ECODE) bus_rdata = err_q;
  end

  assign host_req = req_q;
  assign host_ptr = ptr_q;
endmodule

// File: rtl/semi_doorbell_chk.sv
module semi_doorbell_chk (
  input logic         clk,
  input logic         rst_n,
  input logic [4:0]   bus_addr,
  input logic         bus_wr,
  input logic [7:0]   bus_rdata,
  input logic         host_req,
  input logic         host_done,
  input logic         host_err,
  input logic [7:0]   host_err_code,
  input logic         busy_q,
  input logic         ready_q,
  input logic         perr_q,
  input logic [7:0]   err_q,
  input logic [127:0] ptr_q
);
  p_req_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    host_req |=> !host_req);
  p_ring_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 5'h18 && !busy_q) |=> (host_req && busy_q && !ready_q && !perr_q));
  p_ring_busy_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 5'h18 && busy_q) |=> !host_req);
  p_done_sets_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && host_done) |=> (ready_q && !busy_q));
  p_ready_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_q) |-> $past(host_done));
  p_err_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && host_done && host_err) |=> (perr_q && err_q == $past(host_err_code)));
  p_ptr_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> $stable(ptr_q));
  p_sig_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 5'h00) |-> (bus_rdata == 8'h53));
  p_unused_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr > 5'h1A) |-> (bus_rdata == 8'h00));
endmodule

bind semi_doorbell semi_doorbell_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rdata(bus_rdata), .host_req(host_req), .host_done(host_done),
  .host_err(host_err), .host_err_code(host_err_code), .busy_q(busy_q),
  .ready_q(ready_q), .perr_q(perr_q), .err_q(err_q), .ptr_q(ptr_q)
);

// File: tb/sim_semi_doorbell.sv
`timescale 1ns/1ps
module sim_semi_doorbell;
  logic clk = 0, rst_n = 0;
  logic [4:0] bus_addr = 0;
  logic bus_wr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic host_req;
  logic [127:0] host_ptr;
  logic host_done = 0, host_err = 0, host_timer = 0;
  logic [7:0] host_err_code = 0;
  int checks = 0, errors = 0, req_cnt = 0;
  logic [127:0] exp_ptr = '0;

  always #4 clk = ~clk;

  semi_doorbell u0 (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .host_req(host_req), .host_ptr(host_ptr),
    .host_done(host_done), .host_err(host_err), .host_err_code(host_err_code),
    .host_timer(host_timer));

  always @(posedge clk) if (rst_n && host_req) req_cnt++;

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wr = 1; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(string req, logic [4:0] a, logic [7:0] exp);
    bus_addr = a; #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic done(logic e, logic [7:0] c);
    @(negedge clk); host_done = 1; host_err = e; host_err_code = c;
    @(negedge clk); host_done = 0; host_err = 0; host_err_code = 0;
  endtask

  function automatic logic [7:0] sig(int a);
    case (a)
      0: return 8'h53; 1: return 8'h45; 2: return 8'h4D; 3: return 8'h49;
      4: return 8'h48; 5: return 8'h4F; 6: return 8'h53; default: return 8'h54;
    endcase
  endfunction

  function automatic logic [7:0] idle_view(int a);
    if (a < 8) return sig(a);
    if (a < 24) return exp_ptr[8*(a-8) +: 8];
    return 8'h00;
  endfunction

  initial begin
    #(8*200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 R1 R8: full window after reset
    for (int a = 0; a < 32; a++) rd("R10", 5'(a), idle_view(a));
    check("R10", host_ptr, 128'h0);
    check("R10", host_req, 1'b0);

    // R2: pointer write/readback, parallel view
    for (int k = 0; k < 16; k++) begin
      wr(5'(8 + k), 8'(k * 37 + 5));
      exp_ptr[8*k +: 8] = 8'(k * 37 + 5);
    end
    for (int k = 0; k < 16; k++) rd("R2", 5'(8 + k), 8'(k * 37 + 5));
    check("R2", host_ptr, exp_ptr);

    // R8: read-only offsets keep their values
    for (int a = 0; a < 8; a++) wr(5'(a), 8'hFF);
    wr(5'h19, 8'hFF); wr(5'h1A, 8'hFF);
    for (int a = 0; a < 32; a++) rd("R8", 5'(a), idle_view(a));

    // R7: timer flag
    host_timer = 1; rd("R7", 5'h19, 8'h01);
    host_timer = 0; rd("R7", 5'h19, 8'h00);

    // R5: completion while idle is ignored
    done(1'b1, 8'h77);
    rd("R5", 5'h19, 8'h00);
    rd("R5", 5'h1A, 8'h00);
    check("R5", req_cnt, 0);

    for (int i = 0; i < 4; i++) begin
      logic [7:0] dv;
      logic e;
      dv = (i == 0) ? 8'h00 : (i == 1) ? 8'h5A : (i == 2) ? 8'hFF : 8'h81;
      e = i[0];
      wr(5'h18, dv);
      check("R3", host_req, 1'b1);
      rd("R3", 5'h19, 8'h00);
      rd("R3", 5'h1A, 8'h00);
      @(negedge clk);
      check("R3", host_req, 1'b0);
      wr(5'h18, 8'h11);
      check("R4", host_req, 1'b0);
      @(negedge clk);
      check("R4", host_req, 1'b0);
      wr(5'h08, 8'hC3);
      rd("R9", 5'h08, exp_ptr[7:0]);
      check("R9", host_ptr, exp_ptr);
      done(e, 8'h10 + 8'(i));
      rd("R5", 5'h19, e ? 8'h06 : 8'h02);
      rd("R6", 5'h1A, e ? (8'h10 + 8'(i)) : 8'h00);
    end
    check("R4", req_cnt, 4);

    // R3: next doorbell clears error state left by an error completion
    wr(5'h18, 8'h3C);
    rd("R3", 5'h19, 8'h00);
    rd("R3", 5'h1A, 8'h00);
    done(1'b0, 8'h00);
    // R9: pointer writable again once idle
    wr(5'h08, 8'hC3);
    exp_ptr[7:0] = 8'hC3;
    rd("R9", 5'h08, 8'hC3);
    check("R2", host_ptr, exp_ptr);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule